// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block sits behind one 32-bit write-only register on a register bus. Each accepted write names one of 16 software interrupts, a target filter and an 8-bit CPU list. The block resolves the filter into a set of target CPUs, drawn from up to eight processor interfaces. For every targeted CPU it marks that interrupt pending. It also sets the writer's bit in that interrupt's source mask, leaving any bits already set in place.

Each CPU sees a vector of 16 pending bits and a source mask per interrupt. Each CPU also has an acknowledge port. An acknowledge removes one source bit from one interrupt. The interrupt stops being pending once its source mask is empty. A static input gives the number of CPUs that are present, and CPUs at or above that count are never targeted.

Top module: `sgi_dispatch`

## Requirements
- R1: A synchronous reset clears every pending bit and every source mask. The outputs read zero on the first clock after reset is sampled.
- R2: Filter 0 (field `wr_data[25:24]`=0) targets the CPUs whose bits are set in `wr_data[23:16]`. The interrupt ID is `wr_data[3:0]`, and all other data bits are ignored. The update is visible one clock after the write strobe.
- R3: Filter 1 targets every present CPU except the requester (`wr_req`).
- R4: Filter 2 targets only the requester and ignores the CPU list.
- R5: Filter 3 is reserved. A write with this filter changes no pending bit and no source mask.
- R6: A targeted entry gets bit `wr_req` ORed into its source mask. Bits that are already set stay set.
- R7: CPUs with index at or above `online_cnt` are never targeted, whatever the filter or list.
- R8: Only word-sized writes (`wr_size`=2'b10) take effect. A write of any other size changes no state.
- R9: `rd_data` is always zero.
- R10: An acknowledge on CPU c (`ack_vld[c]`, ID `ack_irq[c*4+:4]`, source `ack_src[c*3+:3]`) clears that source bit one clock later. Pending clears only when the mask becomes empty.
- R11: When an acknowledge and an accepted write hit the same entry in the same cycle, the write wins. The entry stays pending and the requester's bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register |
| wr_size | input | 2 | Access size; 2'b10 is a 32-bit access |
| wr_data | input | 32 | Written word |
| wr_req | input | 3 | ID of the CPU making the write |
| rd_data | output | 32 | Read data, always zero |
| online_cnt | input | 4 | Number of present CPUs, 1 to 8, static |
| ack_vld | input | 8 | Acknowledge strobe, one per CPU |
| ack_irq | input | 32 | Acknowledged interrupt ID, 4 bits per CPU |
| ack_src | input | 24 | Acknowledged source CPU, 3 bits per CPU |
| pending_o | output | 128 | Pending bits, index c*16+irq |
| source_o | output | 1024 | Source masks, bit (c*16+irq)*8+src |

## Verification
The hardest case to reach is the same-cycle collision, where an acknowledge removes the last source bit of an entry while a new write hits that same entry. The acknowledge alone would clear the pending bit. The stimulus first builds an entry that holds a single source and then issues the collision in one driver step. This shows that the pending bit and the source bit survive. A second difficult area is filtering by CPU count. Here the bench changes the count under reset and then writes with every filter, including a requester that sits above the count.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned LIST_LSB = 16;
   localparam int unsigned MODE_LSB = 24;
   localparam logic [1:0]  SIZE_WORD = 2'b10;

   typedef enum logic [1:0] {
      TGT_LIST   = 2'd0,
      TGT_OTHERS = 2'd1,
      TGT_SELF   = 2'd2,
      TGT_RSVD   = 2'd3
   } tgt_mode_e;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
   import sgi_pkg::*;
#(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned IRQ_W   = 4,
   parameter int unsigned CPU_W   = 3,
   parameter int unsigned CNT_W   = 4
) (
   input  logic               wr_en,
   input  logic [1:0]         wr_size,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [CPU_W-1:0]   wr_req,
   input  logic [CNT_W-1:0]   online_cnt,
   output logic [IRQ_W-1:0]   set_irq,
   output logic [NUM_CPU-1:0] set_mask
);
   tgt_mode_e          mode;
   logic               accept;
   logic [NUM_CPU-1:0] online_mask, self_mask, list_mask, raw_mask;
   logic               unused_bits;

   assign mode    = tgt_mode_e'(wr_data[MODE_LSB +: 2]);
   assign set_irq = wr_data[IRQ_W-1:0];
   assign unused_bits = ^{wr_data[REG_W-1:MODE_LSB+2], wr_data[LIST_LSB+7:IRQ_W]};

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      assign online_mask[c] = (CNT_W'(c) < online_cnt);
      assign self_mask[c]   = (wr_req == CPU_W'(c));
      assign list_mask[c]   = wr_data[LIST_LSB + c];
   end

   always_comb begin
      unique case (mode)
         TGT_LIST:   raw_mask = list_mask;
         TGT_OTHERS: raw_mask = ~self_mask;
         TGT_SELF:   raw_mask = self_mask;
         default:    raw_mask = '0;
      endcase
   end

   assign accept   = wr_en && (wr_size == SIZE_WORD) && (mode != TGT_RSVD);
   assign set_mask = accept ? (raw_mask & online_mask) : '0;
endmodule

// File: rtl/sgi_bank.sv
module sgi_bank #(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_IRQ = 16,
   parameter int unsigned IRQ_W   = 4,
   parameter int unsigned CPU_W   = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       set_hit,
   input  logic [IRQ_W-1:0]           set_irq,
   input  logic [CPU_W-1:0]           wr_req,
   input  logic                       ack_vld,
   input  logic [IRQ_W-1:0]           ack_irq,
   input  logic [CPU_W-1:0]           ack_src,
   output logic [NUM_IRQ-1:0]         pend_o,
   output logic [NUM_IRQ*NUM_CPU-1:0] src_o
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      logic [NUM_CPU-1:0] src_q, src_n, clr, add;
      logic               pend_q, pend_n, set_i, ack_i;

      assign set_i  = set_hit && (set_irq == IRQ_W'(i));
      assign ack_i  = ack_vld && (ack_irq == IRQ_W'(i));
      assign clr    = ack_i ? (NUM_CPU'(1) << ack_src) : '0;
      assign add    = set_i ? (NUM_CPU'(1) << wr_req) : '0;
      assign src_n  = (src_q & ~clr) | add;
      assign pend_n = set_i | (pend_q & ~(ack_i && (src_n == '0)));

      always_ff @(posedge clk) begin
         if (rst) begin
            src_q  <= '0;
            pend_q <= 1'b0;
         end else begin
            src_q  <= src_n;
            pend_q <= pend_n;
         end
      end

      assign pend_o[i]                   = pend_q;
      assign src_o[i*NUM_CPU +: NUM_CPU] = src_q;

      // R2
      set_pend_chk: assert property (@(posedge clk) disable iff (rst)
         set_i |=> pend_q);
      // R6
      src_keep_chk: assert property (@(posedge clk) disable iff (rst)
         set_i && !ack_i |=> ((src_q & $past(src_q)) == $past(src_q)));
      // R10
      ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
         ack_i && !set_i |=> !src_q[$past(ack_src)]);
      // R11
      collide_win_chk: assert property (@(posedge clk) disable iff (rst)
         ack_i && set_i |=> pend_q && src_q[$past(wr_req)]);
      // R10
      pend_mask_chk: assert property (@(posedge clk) disable iff (rst)
         pend_q == (src_q != '0));
   end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_pkg::*;
#(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_IRQ = 16,
   localparam int unsigned IRQ_W  = $clog2(NUM_IRQ),
   localparam int unsigned CPU_W  = $clog2(NUM_CPU),
   localparam int unsigned CNT_W  = $clog2(NUM_CPU + 1)
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               wr_en,
   input  logic [1:0]                         wr_size,
   input  logic [REG_W-1:0]                   wr_data,
   input  logic [CPU_W-1:0]                   wr_req,
   output logic [REG_W-1:0]                   rd_data,
   input  logic [CNT_W-1:0]                   online_cnt,
   input  logic [NUM_CPU-1:0]                 ack_vld,
   input  logic [NUM_CPU*IRQ_W-1:0]           ack_irq,
   input  logic [NUM_CPU*CPU_W-1:0]           ack_src,
   output logic [NUM_CPU*NUM_IRQ-1:0]         pending_o,
   output logic [NUM_CPU*NUM_IRQ*NUM_CPU-1:0] source_o
);
   if (NUM_CPU < 2 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be 2..8");
   end
   if (NUM_IRQ < 2 || NUM_IRQ > 16 || (1 << IRQ_W) != NUM_IRQ) begin : g_bad_irq
      $error("NUM_IRQ must be a power of two up to 16");
   end

   logic [IRQ_W-1:0]   set_irq;
   logic [NUM_CPU-1:0] set_mask;

   assign rd_data = '0;

   sgi_decode #(
      .NUM_CPU(NUM_CPU), .IRQ_W(IRQ_W), .CPU_W(CPU_W), .CNT_W(CNT_W)
   ) u_decode (
      .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data), .wr_req(wr_req),
      .online_cnt(online_cnt), .set_irq(set_irq), .set_mask(set_mask)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
      sgi_bank #(
         .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W), .CPU_W(CPU_W)
      ) u_bank (
         .clk(clk), .rst(rst),
         .set_hit(set_mask[c]), .set_irq(set_irq), .wr_req(wr_req),
         .ack_vld(ack_vld[c]),
         .ack_irq(ack_irq[c*IRQ_W +: IRQ_W]),
         .ack_src(ack_src[c*CPU_W +: CPU_W]),
         .pend_o(pending_o[c*NUM_IRQ +: NUM_IRQ]),
         .src_o(source_o[c*NUM_IRQ*NUM_CPU +: NUM_IRQ*NUM_CPU])
      );

      // R7
      offline_quiet_chk: assert property (@(posedge clk) disable iff (rst)
         (CNT_W'(c) >= online_cnt) && !ack_vld[c]
         |=> $stable(pending_o[c*NUM_IRQ +: NUM_IRQ]));
   end

   // R5
   rsvd_noop_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en && (wr_size == SIZE_WORD) && (wr_data[MODE_LSB +: 2] == 2'd3) && (ack_vld == '0)
      |=> $stable(pending_o) && $stable(source_o));
   // R8
   size_reject_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en && (wr_size != SIZE_WORD) && (ack_vld == '0)
      |=> $stable(pending_o) && $stable(source_o));
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (pending_o == '0) && (source_o == '0));
endmodule

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;
   localparam int NC = 8;
   localparam int NI = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_size = 2'b10;
   logic [31:0]   wr_data = '0;
   logic [2:0]    wr_req = '0;
   logic [31:0]   rd_data;
   logic [3:0]    online_cnt = 4'd8;
   logic [7:0]    ack_vld = '0;
   logic [31:0]   ack_irq = '0;
   logic [23:0]   ack_src = '0;
   logic [NC*NI-1:0]    pending_o;
   logic [NC*NI*NC-1:0] source_o;

   sgi_dispatch u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
      .wr_req(wr_req), .rd_data(rd_data), .online_cnt(online_cnt),
      .ack_vld(ack_vld), .ack_irq(ack_irq), .ack_src(ack_src),
      .pending_o(pending_o), .source_o(source_o)
   );

   always #4 clk = ~clk;

   typedef struct {
      logic [NC*NI-1:0]    pend;
      logic [NC*NI*NC-1:0] src;
      string               tag;
   } exp_t;

   exp_t exp_q[$];
   logic [7:0] m_src [NC][NI];
   logic       m_pend[NC][NI];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic model_clear();
      for (int c = 0; c < NC; c++)
         for (int i = 0; i < NI; i++) begin
            m_src[c][i]  = '0;
            m_pend[c][i] = 1'b0;
         end
   endtask

   task automatic push_exp(input string tag);
      exp_t e;
      for (int c = 0; c < NC; c++)
         for (int i = 0; i < NI; i++) begin
            e.pend[c*NI+i]      = m_pend[c][i];
            e.src[(c*NI+i)*NC +: NC] = m_src[c][i];
         end
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Driver: applies one cycle of stimulus, updates the model, queues the result.
   task automatic step(input logic wr, input logic [1:0] sz, input logic [31:0] d,
                       input logic [2:0] req, input logic [7:0] av,
                       input logic [31:0] ai, input logic [23:0] as_, input string tag);
      logic [7:0] tm;
      logic [3:0] irq;
      @(negedge clk);
      wr_en = wr; wr_size = sz; wr_data = d; wr_req = req;
      ack_vld = av; ack_irq = ai; ack_src = as_;
      for (int c = 0; c < NC; c++)
         if (av[c]) begin
            m_src[c][ai[c*4 +: 4]][as_[c*3 +: 3]] = 1'b0;
            if (m_src[c][ai[c*4 +: 4]] == '0) m_pend[c][ai[c*4 +: 4]] = 1'b0;
         end
      irq = d[3:0];
      case (d[25:24])
         2'd0:    tm = d[23:16];
         2'd1:    tm = 8'hFF & ~(8'd1 << req);
         2'd2:    tm = 8'd1 << req;
         default: tm = 8'h00;
      endcase
      if (wr && sz == 2'b10)
         for (int c = 0; c < NC; c++)
            if (tm[c] && c < int'(online_cnt)) begin
               m_pend[c][irq]     = 1'b1;
               m_src[c][irq][req] = 1'b1;
            end
      push_exp(tag);
   endtask

   task automatic do_reset(input logic [3:0] cnt, input string tag);
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b0; ack_vld = '0; online_cnt = cnt;
      model_clear();
      push_exp(tag);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // Monitor: compares after each active edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (pending_o !== e.pend || source_o !== e.src || rd_data !== 32'd0) begin
               fails++;
               $display("FAIL %s: pend=%h exp=%h src_diff=%0d rd=%h exp_rd=0",
                        e.tag, pending_o, e.pend, (source_o !== e.src), rd_data);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      model_clear();
      do_reset(4'd8, "R1 reset clears state");
      step(0, 2'b10, 0, 0, 0, 0, 0, "R1 idle after reset");
      // R2: list mode, stray bits set outside the fields
      step(1, 2'b10, 32'h4005_0403, 3'd1, 0, 0, 0, "R2 list mode cpus 0,2 irq3");
      // R6: second requester accumulates into cpu2 irq3
      step(1, 2'b10, 32'h0004_0003, 3'd4, 0, 0, 0, "R6 source OR accumulate");
      step(1, 2'b10, 32'h0100_0007, 3'd2, 0, 0, 0, "R3 all but requester irq7");
      step(1, 2'b10, 32'h02FF_0009, 3'd5, 0, 0, 0, "R4 self only ignores list");
      step(1, 2'b10, 32'h03FF_0001, 3'd0, 0, 0, 0, "R5 reserved mode no change");
      step(1, 2'b01, 32'h00FF_0002, 3'd0, 0, 0, 0, "R8 halfword write ignored");
      step(1, 2'b00, 32'h00FF_0002, 3'd3, 0, 0, 0, "R8 byte write ignored");
      // R10: cpu2 irq3 holds sources 1 and 4
      step(0, 2'b10, 0, 0, 8'h04, 32'h0000_0300, 24'h000_040, "R10 ack one source pend stays");
      step(0, 2'b10, 0, 0, 8'h04, 32'h0000_0300, 24'h000_100, "R10 ack last source pend clears");
      // R11: cpu0 irq3 holds only source 1; ack and rewrite together
      step(1, 2'b10, 32'h0001_0003, 3'd1, 8'h01, 32'h0000_0003, 24'h000_001, "R11 write wins collision");
      step(0, 2'b10, 0, 0, 8'h01, 32'h0000_0007, 24'h000_001, "R10 ack cpu0 irq7 src1");
      step(0, 2'b10, 0, 0, 0, 0, 0, "R9 read data zero");
      do_reset(4'd3, "R1 reset mid run");
      step(1, 2'b10, 32'h0100_0005, 3'd0, 0, 0, 0, "R7 others limited by count");
      step(1, 2'b10, 32'h00FF_0006, 3'd1, 0, 0, 0, "R7 list limited by count");
      step(1, 2'b10, 32'h0200_0008, 3'd6, 0, 0, 0, "R7 self above count ignored");
      do_reset(4'd1, "R1 reset single cpu");
      step(1, 2'b10, 32'h0100_000A, 3'd0, 0, 0, 0, "R7 others with one cpu empty");
      step(1, 2'b10, 32'h0200_000B, 3'd0, 0, 0, 0, "R4 self with one cpu");
      step(0, 2'b10, 0, 0, 0, 0, 0, "R9 idle final");
      wait (exp_q.size() == 0);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule